// File: doc/BRIEF.md
# Transmit Outcome Status and Interrupt Collector

This block sits beside the transmit path of an Ethernet MAC. While a descriptor's fragment is in flight, it gathers one-cycle outcome pulses from the transmit logic: late collision, excessive collision, excessive deferral, data underrun and a missing follow-on descriptor. When the fragment completes, the block emits a status word for that descriptor with a one-cycle valid strobe. The DMA engine then writes the word back to memory.

The same events feed a small bank of sticky interrupt bits. Software clears these bits by writing ones. Each descriptor may request a completion interrupt. That request is held in a short in-order queue until the DMA reports that the fragment's status has reached memory, and only then is the completion bit raised. A separate bit flags that the descriptor queue has run dry while the transmitter is enabled. A mask selects which bits drive the single interrupt line. A synchronous soft reset returns the transmit status side to idle without touching the mask.

Top module: `txs_aggregator`

## Requirements
- R1: `stat_valid` is high in the cycle after `frag_done`. In that cycle `stat_word` holds the cause flags seen since the previous `frag_done`, including those in the `frag_done` cycle itself. The bits are: bit0 late collision, bit1 excessive collision, bit2 excessive deferral, bit3 underrun, bit4 missing descriptor. The flags then restart empty.
- R2: `stat_word` bit5 is the OR of bits 0 to 2 only. Underrun and missing descriptor never set it.
- R3: `irq_status` bit0 (error) is set in the cycle after a late collision, excessive collision, excessive deferral or missing descriptor pulse. An underrun pulse alone never sets it.
- R4: `irq_status` bit1 (underrun) is set in the cycle after an underrun pulse and by nothing else.
- R5: Each `frag_done` queues its `frag_irq_req` value in a queue of up to `PEND_DEPTH` entries; when full, a new entry is dropped. Each `stat_commit` pops the oldest entry, and has no effect on an empty queue. If the popped entry is 1, `irq_status` bit3 (done) is set in the next cycle. A popped 0 does not set it.
- R6: `irq_status` bit2 (finished) is set only in the cycle after `dq_empty && mac_en` becomes true, having been false in the previous cycle. Holding the condition does not set the bit again after software clears it.
- R7: Interrupt bits are sticky. A `clr_we` pulse clears every bit whose `clr_data` bit is 1. A set event in the same cycle as a clear of that bit leaves the bit set.
- R8: `mask_we` loads `mask_data` into `irq_mask` for the next cycle. `irq` equals the OR of `irq_status & irq_mask`, aligned with those outputs.
- R9: `soft_rst` clears, in the next cycle, all interrupt bits, `irq`, `stat_valid`, the cause flags being gathered, the pending interrupt-request queue and the finished-edge history. `irq_mask` is kept.
- R10: While `rst` is applied, all outputs, including `irq_mask`, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous transmit status reset, mask kept |
| ev_late_col | input | 1 | Late collision pulse |
| ev_exc_col | input | 1 | Excessive collision pulse |
| ev_exc_defer | input | 1 | Excessive deferral pulse |
| ev_underrun | input | 1 | Underrun pulse |
| ev_no_desc | input | 1 | Missing next descriptor pulse |
| frag_done | input | 1 | Fragment finished, status to be produced |
| frag_irq_req | input | 1 | Descriptor interrupt request, sampled with frag_done |
| stat_commit | input | 1 | Oldest pending status now written to memory |
| dq_empty | input | 1 | Descriptor queue empty |
| mac_en | input | 1 | Transmitter enabled |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 4 | Bits to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 4 | New mask value |
| stat_word | output | 6 | Per-fragment status word |
| stat_valid | output | 1 | Status word strobe |
| irq_status | output | 4 | Sticky bits: 0 error, 1 underrun, 2 finished, 3 done |
| irq_mask | output | 4 | Current enable mask |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets the split between the two error summaries. If underrun or missing descriptor leaked into status bit5, or underrun raised the error interrupt, the per-cycle comparison would flag it. It drives set and clear in the same cycle, so a design with clear priority would lose an event. It holds the empty-and-enabled condition across a clear, so a level-sensitive finished bit would reappear. It runs commits against an empty queue and frag_done into a full one, so a tracker that mis-orders or over-accepts requests would raise done at the wrong time. Soft resets with a non-zero mask show whether the mask is wrongly cleared or stale cause flags leak into the next status word.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int IRQ_W  = 4;
  localparam int CAUSE_W = 5;
  localparam int STAT_W = CAUSE_W + 1;

  // interrupt bit positions
  localparam int IB_ERR  = 0;
  localparam int IB_UND  = 1;
  localparam int IB_FIN  = 2;
  localparam int IB_DONE = 3;

  // cause flags, late collision in the least significant bit
  typedef struct packed {
    logic no_desc;
    logic underrun;
    logic exc_defer;
    logic exc_col;
    logic late;
  } tx_cause_t;

  function automatic logic frame_err(input tx_cause_t c);
    return c.late | c.exc_col | c.exc_defer;
  endfunction
endpackage

// File: rtl/txs_frag_status.sv
module txs_frag_status
  import txs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  tx_cause_t         ev,
  input  logic              frag_done,
  output logic [STAT_W-1:0] word,
  output logic              valid
);
  tx_cause_t acc_q;
  tx_cause_t cur;

  assign cur = tx_cause_t'(acc_q | ev);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      acc_q <= '0;
      valid <= 1'b0;
      word  <= '0;
    end else begin
      valid <= frag_done;
      if (frag_done) begin
        word  <= {frame_err(cur), cur};
        acc_q <= '0;
      end else begin
        acc_q <= cur;
      end
    end
  end
endmodule

// File: rtl/txs_done_tracker.sv
module txs_done_tracker #(
  parameter int PEND_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic push,
  input  logic push_bit,
  input  logic pop,
  output logic done_set
);
  localparam int PTR_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
  localparam int CNT_W = $clog2(PEND_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PEND_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PEND_DEPTH);

  logic             mem [PEND_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok   = pop && (cnt != '0);
  assign push_ok  = push && ((cnt != FULL_CNT) || pop_ok);
  assign done_set = pop_ok && mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_bit;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/txs_irq_bank.sv
module txs_irq_bank #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic [NBITS-1:0] set_vec,
  input  logic             clr_we,
  input  logic [NBITS-1:0] clr_data,
  input  logic             mask_we,
  input  logic [NBITS-1:0] mask_data,
  output logic [NBITS-1:0] status,
  output logic [NBITS-1:0] mask,
  output logic             irq
);
  logic [NBITS-1:0] st_nxt;
  logic [NBITS-1:0] mask_nxt;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_comb begin
      if (soft_rst)                 st_nxt[i] = 1'b0;
      else if (set_vec[i])          st_nxt[i] = 1'b1;
      else if (clr_we && clr_data[i]) st_nxt[i] = 1'b0;
      else                          st_nxt[i] = status[i];
    end
  end

  assign mask_nxt = mask_we ? mask_data : mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= st_nxt;
      mask   <= mask_nxt;
      irq    <= |(st_nxt & mask_nxt);
    end
  end
endmodule

// File: rtl/txs_aggregator.sv
module txs_aggregator
  import txs_pkg::*;
#(
  parameter int PEND_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              ev_late_col,
  input  logic              ev_exc_col,
  input  logic              ev_exc_defer,
  input  logic              ev_underrun,
  input  logic              ev_no_desc,
  input  logic              frag_done,
  input  logic              frag_irq_req,
  input  logic              stat_commit,
  input  logic              dq_empty,
  input  logic              mac_en,
  input  logic              clr_we,
  input  logic [IRQ_W-1:0]  clr_data,
  input  logic              mask_we,
  input  logic [IRQ_W-1:0]  mask_data,
  output logic [STAT_W-1:0] stat_word,
  output logic              stat_valid,
  output logic [IRQ_W-1:0]  irq_status,
  output logic [IRQ_W-1:0]  irq_mask,
  output logic              irq
);
  tx_cause_t        ev;
  logic             done_set;
  logic             fin_cond, fin_prev;
  logic [IRQ_W-1:0] set_vec;

  assign ev.late      = ev_late_col;
  assign ev.exc_col   = ev_exc_col;
  assign ev.exc_defer = ev_exc_defer;
  assign ev.underrun  = ev_underrun;
  assign ev.no_desc   = ev_no_desc;

  txs_frag_status u_stat (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .ev        (ev),
    .frag_done (frag_done),
    .word      (stat_word),
    .valid     (stat_valid)
  );

  txs_done_tracker #(.PEND_DEPTH(PEND_DEPTH)) u_done (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .push     (frag_done),
    .push_bit (frag_irq_req),
    .pop      (stat_commit),
    .done_set (done_set)
  );

  assign fin_cond = dq_empty && mac_en;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) fin_prev <= 1'b0;
    else                 fin_prev <= fin_cond;
  end

  always_comb begin
    set_vec          = '0;
    set_vec[IB_ERR]  = frame_err(ev) | ev.no_desc;
    set_vec[IB_UND]  = ev.underrun;
    set_vec[IB_FIN]  = fin_cond && !fin_prev;
    set_vec[IB_DONE] = done_set;
  end

  txs_irq_bank #(.NBITS(IRQ_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .set_vec   (set_vec),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .mask_we   (mask_we),
    .mask_data (mask_data),
    .status    (irq_status),
    .mask      (irq_mask),
    .irq       (irq)
  );
endmodule

// File: rtl/txs_agg_chk.sv
module txs_agg_chk
  import txs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              ev_late_col,
  input logic              ev_exc_col,
  input logic              ev_exc_defer,
  input logic              ev_underrun,
  input logic              ev_no_desc,
  input logic              frag_done,
  input logic              frag_irq_req,
  input logic              stat_commit,
  input logic              dq_empty,
  input logic              mac_en,
  input logic              clr_we,
  input logic [IRQ_W-1:0]  clr_data,
  input logic              mask_we,
  input logic [IRQ_W-1:0]  mask_data,
  input logic [STAT_W-1:0] stat_word,
  input logic              stat_valid,
  input logic [IRQ_W-1:0]  irq_status,
  input logic [IRQ_W-1:0]  irq_mask,
  input logic              irq
);
  // R1
  valid_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    (frag_done && !soft_rst) |=> stat_valid);
  // R1
  valid_only_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    !frag_done |=> !stat_valid);
  // R2
  summary_err_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (stat_word[5] == (stat_word[0] | stat_word[1] | stat_word[2])));
  // R3
  err_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && (ev_late_col || ev_exc_col || ev_exc_defer || ev_no_desc)) |=> irq_status[IB_ERR]);
  // R4
  und_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && ev_underrun) |=> irq_status[IB_UND]);
  // R4
  und_irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[IB_UND]) |-> $past(ev_underrun));
  // R5
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[IB_DONE]) |-> $past(stat_commit));
  // R6
  fin_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status[IB_FIN]) |-> $past(dq_empty && mac_en));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> (($past(irq_status) & ~($past(clr_we) ? $past(clr_data) : '0) & ~irq_status) == '0));
  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_status & irq_mask));
  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (irq_status == '0 && !stat_valid && !irq));
endmodule

bind txs_aggregator txs_agg_chk u_chk (.*);

// File: tb/sim_txs_aggregator.sv
`timescale 1ns/1ps
module sim_txs_aggregator;
  localparam int DEPTH = 4;
  localparam real CLK_PER = 20.0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0;
  logic ev_late_col = 0, ev_exc_col = 0, ev_exc_defer = 0, ev_underrun = 0, ev_no_desc = 0;
  logic frag_done = 0, frag_irq_req = 0, stat_commit = 0, dq_empty = 0, mac_en = 0;
  logic clr_we = 0, mask_we = 0;
  logic [3:0] clr_data = '0, mask_data = '0;
  logic [5:0] stat_word;
  logic       stat_valid;
  logic [3:0] irq_status, irq_mask;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #(CLK_PER/2) clk = ~clk;

  txs_aggregator #(.PEND_DEPTH(DEPTH)) u0 (.*);

  // behavioural reference model
  bit   m_q[$];
  logic [4:0] m_acc = '0;
  logic [5:0] m_word = '0;
  logic m_valid = 0, m_prev = 0, m_irq = 0;
  logic [3:0] m_st = '0, m_mask = '0;

  always @(posedge clk) begin
    logic [4:0] ev, cur;
    logic [3:0] setv;
    logic done_hit, cond;
    ev = {ev_no_desc, ev_underrun, ev_exc_defer, ev_exc_col, ev_late_col};
    cond = dq_empty && mac_en;
    if (rst) begin
      m_acc = 0; m_word = 0; m_valid = 0; m_prev = 0; m_st = 0; m_mask = 0; m_irq = 0;
      m_q.delete();
    end else begin
      if (mask_we) m_mask = mask_data;
      if (soft_rst) begin
        m_acc = 0; m_word = 0; m_valid = 0; m_prev = 0; m_st = 0;
        m_q.delete();
      end else begin
        cur = m_acc | ev;
        m_valid = frag_done;
        if (frag_done) begin
          m_word = {(cur[0] | cur[1] | cur[2]), cur};
          m_acc = 0;
        end else m_acc = cur;
        done_hit = 0;
        if (stat_commit && m_q.size() > 0) done_hit = m_q.pop_front();
        if (frag_done && m_q.size() < DEPTH) m_q.push_back(frag_irq_req);
        setv[0] = ev[0] | ev[1] | ev[2] | ev[4];
        setv[1] = ev[3];
        setv[2] = cond && !m_prev;
        setv[3] = done_hit;
        if (clr_we) m_st = m_st & ~clr_data;
        m_st = m_st | setv;
        m_prev = cond;
      end
      m_irq = |(m_st & m_mask);
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done_flag) begin
      check("R1 stat_valid", 8'(stat_valid), 8'(m_valid));
      if (m_valid) begin
        check("R1 stat_word causes", 8'(stat_word[4:0]), 8'(m_word[4:0]));
        check("R2 stat_word summary", 8'(stat_word[5]), 8'(m_word[5]));
      end
      check("R3 irq error bit", 8'(irq_status[0]), 8'(m_st[0]));
      check("R4 irq underrun bit", 8'(irq_status[1]), 8'(m_st[1]));
      check("R6 irq finished bit", 8'(irq_status[2]), 8'(m_st[2]));
      check("R5 irq done bit", 8'(irq_status[3]), 8'(m_st[3]));
      check("R8 irq_mask", 8'(irq_mask), 8'(m_mask));
      check("R8 irq line", 8'(irq), 8'(m_irq));
    end
  end

  task automatic idle_inputs();
    {ev_late_col, ev_exc_col, ev_exc_defer, ev_underrun, ev_no_desc} = '0;
    frag_done = 0; frag_irq_req = 0; stat_commit = 0;
    clr_we = 0; clr_data = '0; mask_we = 0; mask_data = '0; soft_rst = 0;
  endtask

  task automatic step();
    @(negedge clk); #1;
    idle_inputs();
  endtask

  task automatic random_cycle(input int ev_pct, input int srst_pct);
    @(negedge clk); #1;
    idle_inputs();
    ev_late_col  = ($urandom_range(99) < ev_pct);
    ev_exc_col   = ($urandom_range(99) < ev_pct);
    ev_exc_defer = ($urandom_range(99) < ev_pct);
    ev_underrun  = ($urandom_range(99) < ev_pct);
    ev_no_desc   = ($urandom_range(99) < ev_pct);
    frag_done    = ($urandom_range(99) < 25);
    frag_irq_req = $urandom_range(1);
    stat_commit  = ($urandom_range(99) < 25);
    if ($urandom_range(99) < 10) dq_empty = ~dq_empty;
    if ($urandom_range(99) < 5)  mac_en = ~mac_en;
    clr_we   = ($urandom_range(99) < 15);
    clr_data = 4'($urandom);
    mask_we  = ($urandom_range(99) < 5);
    mask_data = 4'($urandom);
    soft_rst = ($urandom_range(999) < srst_pct);
  endtask

  initial begin
    // R10: outputs zero under reset
    repeat (3) @(negedge clk);
    check("R10 reset stat_valid", 8'(stat_valid), 8'h0);
    check("R10 reset irq_status", 8'(irq_status), 8'h0);
    check("R10 reset irq_mask", 8'(irq_mask), 8'h0);
    check("R10 reset irq", 8'(irq), 8'h0);
    #1 rst = 0;
    step();

    // R2/R3/R4: underrun and missing descriptor only, no summary error
    mask_we = 1; mask_data = 4'hF;
    ev_underrun = 1;
    step();
    ev_no_desc = 1; frag_done = 1; frag_irq_req = 1;
    step();
    step();
    check("R2 summary excludes underrun/no_desc", 8'(stat_word), 8'h18);

    // R7: clear and set in the same cycle keeps the bit
    @(negedge clk); #1;
    clr_we = 1; clr_data = 4'h2; ev_underrun = 1;
    step();
    check("R7 set beats clear", 8'(irq_status[1]), 8'h1);
    clr_we = 1; clr_data = 4'hF;
    step();
    check("R7 clear all", 8'(irq_status), 8'h0);

    // R5: commit pops request queued above
    stat_commit = 1;
    step();
    check("R5 done after commit", 8'(irq_status[3]), 8'h1);
    stat_commit = 1;  // empty queue: no effect
    clr_we = 1; clr_data = 4'h8;
    step();
    step();
    check("R5 commit on empty queue", 8'(irq_status[3]), 8'h0);

    // R6: hold empty-and-enabled across a clear
    dq_empty = 1; mac_en = 1;
    step();
    check("R6 finished on rise", 8'(irq_status[2]), 8'h1);
    clr_we = 1; clr_data = 4'h4;
    step();
    repeat (4) step();
    check("R6 level does not re-set", 8'(irq_status[2]), 8'h0);

    // R9: soft reset keeps mask
    ev_late_col = 1;
    step();
    soft_rst = 1;
    step();
    step();
    check("R9 soft reset keeps mask", 8'(irq_mask), 8'hF);

    // randomized phases of differing density
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 3000; n++) random_cycle(2 + ph * 8, (ph == 3) ? 20 : 3);
    end
    step();
    step();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule